// File: doc/BRIEF.md
# CRC-Checked Serial Register Target

This block is the peripheral side of a full-duplex serial link that moves one fixed 32-bit frame per chip-select window. The controller shifts in a command frame. The block shifts out a response frame at the same time. Both frames end in a 4-bit CRC. The block keeps a small register file. A write is committed only once all 32 incoming bits are in and the CRC matches. A read returns the addressed register in the same frame that requested it.

The block reports a corrupted incoming frame in two ways. First, it flips the last outgoing bit of that same frame. The controller therefore learns of the error before the chip select is released. Second, a sticky flag is set. The flag shows up in the status field of later frames and clears after a clean read has carried it out. The serial clock, chip select and data in are sampled on a faster system clock. They must already be synchronous to that clock.

Top module: `crc_spi_target`

## Requirements
- R1: Every frame is 32 bits, MSB first. SDI is taken on each rising SCLK edge while cs_n is low, and SDO moves to the next bit after each falling SCLK edge. Frame bit 31 is on SDO as soon as cs_n goes low, before the first rising edge.
- R2: Bits 3:0 of the response frame carry a CRC over its bits 31:4. The CRC uses generator x^4+x+1 with the remainder preset to 4'b1111. It is processed MSB first over the 28 payload bits and then four zero bits.
- R3: Command frame layout: bit 31 is 1 for write and 0 for read, bits 30:24 the address, bits 23:8 the write data, bits 7:4 ignored, and bits 3:0 the CRC (computed as in R2). A write with a matching CRC and an address below NREG replaces that register on the 32nd rising edge.
- R4: A frame whose received CRC differs from the CRC of its own bits 31:4 changes no register.
- R5: Response bits 15:4 hold bits 11:0 of the register addressed in the same frame. An address of NREG or above returns zero and aliases no register.
- R6: When the received CRC does not match, the final SDO bit (response bit 0) is inverted in the same frame. It is valid before the 32nd rising edge. For a matching frame it is not inverted.
- R7: A mismatching frame sets a sticky flag. Response bit 30 carries the flag and bit 31 is the error summary (equal to the flag); bits 29:16 are zero. The flag is cleared by a matching read frame and kept by a matching write frame.
- R8: Raising cs_n before 32 bits abandons the frame: no register change, no flag change, and the next frame starts from bit 31.
- R9: Reset clears the flag and preloads register i with (i * 16'h1111) XOR 16'hA55A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial data to the controller |

## Verification
The last incoming CRC bit is checked in the same cycle that the last outgoing bit must already be driven. The inverted bit is therefore formed combinationally from the running check and the live SDI level. The bench provokes this by sending frames whose CRC has one bit flipped. It reads SDO just before the 32nd rising edge, with the final SDI bit already applied, and compares it against a response CRC that the bench computes itself by polynomial long division. On that same edge, the write commit and the sticky flag update also take effect. A later read of the same register and the status field of the following frame show that the write was discarded and the flag was raised.

// File: rtl/crcspi_pkg.sv
package crcspi_pkg;

    localparam int FRAME_W = 32;
    localparam int PAY_W   = 28;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int RD_W    = 12;
    localparam logic [3:0] CRC_SEED = 4'hF;

    // One serial step of the x^4 + x + 1 remainder, data bit entering at the top.
    function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
        logic fb;
        fb = b ^ c[3];
        return {c[2], c[1], c[0] ^ fb, fb};
    endfunction

    // Append four zero bits to a running remainder.
    function automatic logic [3:0] crc4_flush(input logic [3:0] c);
        logic [3:0] r;
        r = c;
        for (int k = 0; k < 4; k++) r = crc4_step(r, 1'b0);
        return r;
    endfunction

    function automatic logic [3:0] crc4_payload(input logic [PAY_W-1:0] p);
        logic [3:0] r;
        r = CRC_SEED;
        for (int k = PAY_W - 1; k >= 0; k--) r = crc4_step(r, p[k]);
        return crc4_flush(r);
    endfunction

endpackage

// File: rtl/crcspi_rx.sv
module crcspi_rx
    import crcspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rise,
    input  logic              sdi,
    output logic [5:0]        cnt,
    output logic              addr_stb,
    output logic [ADDR_W-1:0] addr,
    output logic              frame_stb,
    output logic              frame_wr,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_good,
    output logic              live_bad,
    output logic              bad_q
);
    localparam logic [5:0] LAST    = 6'(FRAME_W - 1);
    localparam logic [5:0] PAY_END = 6'(PAY_W);
    localparam logic [5:0] ADDR_AT = 6'(ADDR_W);

    typedef struct packed {
        logic [5:0]         cnt;
        logic [FRAME_W-2:0] sh;
        logic [3:0]         crc;
        logic               bad;
    } rx_t;

    localparam rx_t RX_RST = '{cnt: '0, sh: '0, crc: CRC_SEED, bad: 1'b0};

    rx_t q, d;
    logic [3:0] exp_crc;
    logic [3:0] rcv_crc;
    logic [FRAME_W-1:0] word;

    always_comb begin
        exp_crc  = crc4_flush(q.crc);
        rcv_crc  = {q.sh[2:0], sdi};
        live_bad = (rcv_crc != exp_crc);
        word     = {q.sh, sdi};
        d        = q;
        if (cs_n) begin
            d.cnt = '0;
            d.crc = CRC_SEED;
            d.bad = 1'b0;
        end else if (rise && q.cnt <= LAST) begin
            d.sh  = word[FRAME_W-2:0];
            d.cnt = q.cnt + 6'd1;
            if (q.cnt < PAY_END) d.crc = crc4_step(q.crc, sdi);
            if (q.cnt == LAST)   d.bad = live_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RST;
        else        q <= d;
    end

    assign cnt        = q.cnt;
    assign bad_q      = q.bad;
    assign addr_stb   = !cs_n && rise && (q.cnt == ADDR_AT);
    assign addr       = word[ADDR_W-1:0];
    assign frame_stb  = !cs_n && rise && (q.cnt == LAST);
    assign frame_wr   = word[FRAME_W-1];
    assign frame_addr = word[FRAME_W-2 -: ADDR_W];
    assign frame_data = word[FRAME_W-2-ADDR_W -: DATA_W];
    assign frame_good = !live_bad;

    // R8: a released select restarts the bit count and the remainder
    p_restart_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (q.cnt == 6'd0 && q.crc == CRC_SEED));

    // R1: one bit taken per rising edge inside a frame
    p_one_bit_per_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rise && q.cnt < LAST) |=> (q.cnt == $past(q.cnt) + 6'd1));
endmodule

// File: rtl/crcspi_regs.sv
module crcspi_regs
    import crcspi_pkg::*;
#(
    parameter int          NREG      = 8,
    parameter logic [15:0] INIT_BASE = 16'hA55A,
    parameter logic [15:0] INIT_STEP = 16'h1111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              frame_good,
    input  logic              frame_wr,
    input  logic [ADDR_W-1:0] frame_addr,
    input  logic [DATA_W-1:0] frame_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data,
    output logic              crc_flag
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(NREG);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic                        flag;
    } rf_t;

    rf_t q, d;
    logic wr_hit;

    always_comb begin
        wr_hit = frame_addr < TOP;
        d      = q;
        if (frame_stb) begin
            if (!frame_good)   d.flag = 1'b1;
            else if (!frame_wr) d.flag = 1'b0;
            else if (wr_hit)   d.regs[frame_addr[IDX_W-1:0]] = frame_data;
        end
        rd_data = (rd_addr < TOP) ? q.regs[rd_addr[IDX_W-1:0]][RD_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                q.regs[i] <= INIT_BASE ^ DATA_W'(INIT_STEP * i);
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign crc_flag = q.flag;

    // R4: a mismatching frame leaves every register alone
    p_bad_frame_keeps_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !frame_good) |=> $stable(q.regs));

    // R7: mismatch raises the flag, clean read drops it
    p_bad_frame_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !frame_good) |=> q.flag);
    p_clean_read_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && frame_good && !frame_wr) |=> !q.flag);

    // R8: without a completed frame nothing in the file moves
    p_no_frame_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(q.regs) && $stable(q.flag)));

    // R3: a clean in-range write lands its data
    p_clean_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && frame_good && frame_wr && frame_addr < TOP)
        |=> (q.regs[$past(frame_addr[IDX_W-1:0])] == $past(frame_data)));
endmodule

// File: rtl/crcspi_tx.sv
module crcspi_tx
    import crcspi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            fall,
    input  logic [5:0]      cnt,
    input  logic            addr_stb,
    input  logic [RD_W-1:0] rd_data,
    input  logic [15:0]     status,
    input  logic            live_bad,
    input  logic            bad_q,
    output logic            sdo
);
    localparam logic [4:0] FIRST = 5'(FRAME_W - 1);
    localparam logic [5:0] LAST  = 6'(FRAME_W - 1);
    localparam logic [5:0] DONE  = 6'(FRAME_W);

    typedef struct packed {
        logic [PAY_W-1:0] pay;
        logic [4:0]       pos;
    } tx_t;

    tx_t q, d;
    logic [3:0] out_crc;
    logic       raw_bit;
    logic       flip;

    always_comb begin
        d = q;
        if (cs_n) begin
            d.pay = {status, {RD_W{1'b0}}};
            d.pos = FIRST;
        end else begin
            if (fall && q.pos != 5'd0) d.pos = q.pos - 5'd1;
            if (addr_stb)              d.pay[RD_W-1:0] = rd_data;
        end
        out_crc = crc4_payload(q.pay);
        raw_bit = (q.pos >= 5'd4) ? q.pay[q.pos - 5'd4] : out_crc[q.pos[1:0]];
        flip    = !cs_n && (q.pos == 5'd0) &&
                  ((cnt == LAST && live_bad) || (cnt == DONE && bad_q));
        sdo     = raw_bit ^ flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pay <= '0;
            q.pos <= FIRST;
        end else begin
            q <= d;
        end
    end

    // R1: an idle select parks the pointer on frame bit 31
    p_pointer_parks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (q.pos == FIRST));
    // R1: each falling edge inside a frame advances one bit
    p_pointer_steps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && fall && q.pos != 5'd0) |=> (q.pos == $past(q.pos) - 5'd1));
endmodule

// File: rtl/crc_spi_target.sv
module crc_spi_target
    import crcspi_pkg::*;
#(
    parameter int          NREG      = 8,
    parameter logic [15:0] INIT_BASE = 16'hA55A,
    parameter logic [15:0] INIT_STEP = 16'h1111
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdo
);
    typedef struct packed {
        logic sclk;
    } edge_t;

    edge_t q, d;
    logic rise, fall;

    logic [5:0]        cnt;
    logic              addr_stb;
    logic [ADDR_W-1:0] addr;
    logic              frame_stb, frame_wr, frame_good;
    logic [ADDR_W-1:0] frame_addr;
    logic [DATA_W-1:0] frame_data;
    logic              live_bad, bad_q;
    logic [RD_W-1:0]   rd_data;
    logic              crc_flag;
    logic [15:0]       status;

    always_comb begin
        d.sclk = sclk;
        rise   = sclk && !q.sclk;
        fall   = !sclk && q.sclk;
        status = {crc_flag, crc_flag, 14'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.sclk <= 1'b0;
        else        q <= d;
    end

    crcspi_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .sdi(sdi),
        .cnt(cnt), .addr_stb(addr_stb), .addr(addr),
        .frame_stb(frame_stb), .frame_wr(frame_wr), .frame_addr(frame_addr),
        .frame_data(frame_data), .frame_good(frame_good),
        .live_bad(live_bad), .bad_q(bad_q)
    );

    crcspi_regs #(.NREG(NREG), .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)) u_regs (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame_good(frame_good),
        .frame_wr(frame_wr), .frame_addr(frame_addr), .frame_data(frame_data),
        .rd_addr(addr), .rd_data(rd_data), .crc_flag(crc_flag)
    );

    crcspi_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall(fall), .cnt(cnt),
        .addr_stb(addr_stb), .rd_data(rd_data), .status(status),
        .live_bad(live_bad), .bad_q(bad_q), .sdo(sdo)
    );

    // R6: a clean completed frame never leaves the inversion armed
    p_clean_frame_not_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && frame_good) |=> !bad_q);
endmodule

// File: tb/crc_spi_target_tb.sv
module crc_spi_target_tb;
    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo;
    int   errs = 0, checks = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    crc_spi_target u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo));

    typedef struct packed {
        logic        wr;
        logic [6:0]  addr;
        logic [15:0] data;
        logic [3:0]  rsv;
        logic        bad;
        logic [11:0] rd;
        logic        flag;
    } vec_t;

    localparam vec_t VEC [15] = '{
        '{1'b0, 7'd0, 16'h0000, 4'h0, 1'b0, 12'h55A, 1'b0}, // R5 R9 reset content
        '{1'b0, 7'd3, 16'h0000, 4'h0, 1'b0, 12'h669, 1'b0}, // R5
        '{1'b1, 7'd2, 16'h1234, 4'h0, 1'b0, 12'h778, 1'b0}, // R3 write returns old value
        '{1'b0, 7'd2, 16'h0000, 4'h0, 1'b0, 12'h234, 1'b0}, // R3 committed
        '{1'b1, 7'd2, 16'hBEEF, 4'h0, 1'b1, 12'h234, 1'b0}, // R4 R6 bad write
        '{1'b0, 7'd2, 16'h0000, 4'h0, 1'b0, 12'h234, 1'b1}, // R4 unchanged, R7 reported
        '{1'b0, 7'd2, 16'h0000, 4'h0, 1'b0, 12'h234, 1'b0}, // R7 cleared
        '{1'b0, 7'd9, 16'h0000, 4'h0, 1'b0, 12'h000, 1'b0}, // R5 out of range
        '{1'b1, 7'd9, 16'hFFFF, 4'h0, 1'b0, 12'h000, 1'b0}, // R5 out-of-range write
        '{1'b0, 7'd1, 16'h0000, 4'h0, 1'b0, 12'h44B, 1'b0}, // R5 no aliasing
        '{1'b0, 7'd7, 16'h0000, 4'h0, 1'b0, 12'h22D, 1'b0}, // R5
        '{1'b0, 7'd7, 16'h0000, 4'h0, 1'b1, 12'h22D, 1'b0}, // R6 bad read
        '{1'b1, 7'd5, 16'h0ABC, 4'hA, 1'b0, 12'h00F, 1'b1}, // R3 bits 7:4 ignored, R7 kept
        '{1'b0, 7'd5, 16'h0000, 4'h0, 1'b0, 12'hABC, 1'b1}, // R3 R7
        '{1'b0, 7'd5, 16'h0000, 4'h0, 1'b0, 12'hABC, 1'b0}  // R7 cleared
    };

    // Long division of (seed * x^32 + payload * x^8) by 10011
    function automatic logic [3:0] ref_crc(input logic [27:0] p);
        logic [35:0] v;
        v = {4'hF, 32'h0} ^ {p, 8'h0};
        for (int i = 35; i >= 4; i--)
            if (v[i]) v[i -: 5] = v[i -: 5] ^ 5'b10011;
        return v[3:0];
    endfunction

    function automatic logic [31:0] cmd(input logic wr, input logic [6:0] a,
                                        input logic [15:0] dt, input logic [3:0] rsv,
                                        input logic bad);
        logic [27:0] p;
        p = {wr, a, dt, rsv};
        return {p, ref_crc(p) ^ (bad ? 4'b0010 : 4'b0000)};
    endfunction

    function automatic logic [31:0] rsp(input logic flag, input logic [11:0] rd, input logic bad);
        logic [27:0] p;
        p = {flag, flag, 14'b0, rd};
        return {p, ref_crc(p) ^ {3'b000, bad}};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic xfer(input logic [31:0] mosi, input int nbits, output logic [31:0] miso);
        @(negedge clk);
        cs_n = 1'b0;
        miso = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi = mosi[31 - i];
            half();
            miso[31 - i] = sdo;   // sampled just before the rising edge (R1, R6)
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
        half();
        cs_n = 1'b1;
        sdi  = 1'b0;
        half();
        half();
    endtask

    task automatic frame_check(input vec_t v);
        logic [31:0] got, want;
        xfer(cmd(v.wr, v.addr, v.data, v.rsv, v.bad), 32, got);
        want = rsp(v.flag, v.rd, v.bad);
        chk("R7 status", {16'b0, got[31:16]}, {16'b0, want[31:16]});
        chk("R5 data",   {20'b0, got[15:4]},  {20'b0, want[15:4]});
        chk(v.bad ? "R6 crc" : "R2 crc", {28'b0, got[3:0]}, {28'b0, want[3:0]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        half();
        chk("R9 idle status", {31'b0, sdo}, 32'h0);

        for (int n = 0; n < 15; n++) frame_check(VEC[n]);

        // R8: aborted clean write, then aborted bad write
        xfer(cmd(1'b1, 7'd4, 16'h7777, 4'h0, 1'b0), 31, got);
        xfer(cmd(1'b1, 7'd4, 16'h7777, 4'h0, 1'b1), 20, got);
        xfer(cmd(1'b0, 7'd4, 16'h0000, 4'h0, 1'b0), 32, got);
        chk("R8 abort no write", got, rsp(1'b0, 12'h11E, 1'b0));

        // R1: first bit valid before any rising edge, flag set by a bad frame
        xfer(cmd(1'b0, 7'd0, 16'h0000, 4'h0, 1'b1), 32, got);
        @(negedge clk);
        cs_n = 1'b0;
        half();
        chk("R1 first bit", {31'b0, sdo}, 32'h1);
        cs_n = 1'b1;
        half();

        // R9: reset restores contents and clears the flag
        xfer(cmd(1'b1, 7'd2, 16'h4321, 4'h0, 1'b0), 32, got);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        half();
        xfer(cmd(1'b0, 7'd2, 16'h0000, 4'h0, 1'b0), 32, got);
        chk("R9 reset content and flag", got, rsp(1'b0, 12'h778, 1'b0));

        finish_run();
    end
endmodule